// File: doc/BRIEF.md
# Paged Indirect Register Access Master

This block is a host-side sequencer that reaches a switch's internal paged register space through a narrow window of 16-bit management registers. All of that window sits at one fixed management address. A local requester gives the page, the register offset, the direction, an access width of 8, 16, 32, 48 or 64 bits, and the write data. The block turns the request into a series of single 16-bit management reads and writes. It then returns the assembled read data with a one-cycle done pulse and an error flag.

The management side is an abstract transaction port. The block holds a request until the responder acknowledges it. The responder's acknowledge may carry an error indication and, for reads, the 16-bit read data.

The block keeps the last page it selected and skips the page write when the next access stays on that page. Writes load the data window before the command is issued. After the command, the block polls the command register a bounded number of times, with a programmable gap between polls, and gives up with an error if the busy bits never clear.

Top module: `paged_reg_master`

## Requirements
- R1: Before an access, the block writes management register 0x10 with the page in bits 15:8, bit 0 set and bits 7:1 clear, but only when the requested page differs from the cached page. The cache holds 0xFF after reset, so a first access to page 0xFF skips the page write.
- R2: The page cache takes the new page only when the page write is acknowledged without error. After a failed page write, the next access to the same page writes the page again.
- R3: `req_size_i` encodes 0 as 8 bits, 1 as 16, 2 as 32, 3 as 48 and 4 or more as 64, using 1, 1, 2, 3 and 4 data lanes. A write first loads data registers 0x18 upward in ascending order, with lane k taking write data bits 16k+15:16k, and issues the command only after them.
- R4: The command is a write to register 0x11 carrying the offset in bits 15:8, bits 7:2 clear, bit 1 set for a read and bit 0 set for a write. Every management transaction targets address `PHY_ADDR` (30 by default).
- R5: After the command, the block reads register 0x11 at once, and again after every reply with bit 0 or bit 1 set. Between one poll's acknowledge and the next poll's request, `mgmt_req_o` stays low for exactly `poll_gap_i`+1 cycles.
- R6: If the fifth poll still shows a busy bit, the access ends with `err_o` set, no data reads and `rdata_o` equal to zero.
- R7: A read fetches data registers 0x18 upward, one per lane, only after the busy bits clear, and places lane k at `rdata_o` bits 16k+15:16k. An 8-bit read returns only the low byte of register 0x18.
- R8: An error acknowledge on any management transaction ends the access at once, with `done_o` and `err_o` both set and `rdata_o` equal to zero.
- R9: A request is taken only while `busy_o` is low. `busy_o` rises in the cycle after acceptance and stays high through the done cycle. A `req_valid_i` seen while the block is busy is ignored.
- R10: `done_o` is a single-cycle pulse for each accepted request. `mgmt_req_o` and its register, write flag and data are held stable until acknowledged. Within one access, the transactions other than polls follow each other with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_page_i | input | 8 | Target page |
| req_ofs_i | input | 8 | Register offset within the page |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 3 | Access width code (see R3) |
| req_wdata_i | input | 64 | Write data, least significant lane in bits 15:0 |
| poll_gap_i | input | 8 | Idle cycles between busy polls, minus one |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Access finished (one cycle) |
| err_o | output | 1 | Access failed, valid with done_o |
| rdata_o | output | 64 | Read result, valid with done_o |
| mgmt_req_o | output | 1 | Management transaction request |
| mgmt_we_o | output | 1 | Transaction is a write |
| mgmt_phy_o | output | 5 | Management device address |
| mgmt_reg_o | output | 5 | Management register number |
| mgmt_wdata_o | output | 16 | Write data of the transaction |
| mgmt_ack_i | input | 1 | Transaction acknowledge (one cycle) |
| mgmt_err_i | input | 1 | Transaction failed, valid with mgmt_ack_i |
| mgmt_rdata_i | input | 16 | Read data, valid with mgmt_ack_i |

## Verification
The properties assume that the responder raises `mgmt_ack_i` only while `mgmt_req_o` is high, for one cycle per transaction. They also assume that `mgmt_err_i` and `mgmt_rdata_i` matter only in the acknowledge cycle. The bench's responder keeps to this. It acknowledges each held request after a per-access latency of zero to two cycles and drops the acknowledge on the next falling edge. It models the busy bits with a per-access count of busy replies and injects an error at one chosen transaction index. Requests are driven away from the clock edge, and the only request raised while busy is the deliberate one that checks R9.

// File: rtl/pram_pkg.sv
package pram_pkg;
  localparam int MREG_W = 5;
  localparam logic [MREG_W-1:0] MREG_PAGE  = 5'h10;
  localparam logic [MREG_W-1:0] MREG_CMD   = 5'h11;
  localparam logic [MREG_W-1:0] MREG_DATA0 = 5'h18;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PAGE, ST_WDATA, ST_CMD, ST_POLL, ST_GAP, ST_RDATA, ST_FIN
  } seq_state_e;

  // index of the most significant lane used by a width code
  function automatic int size_last_lane(input logic [2:0] sz, input int lanes);
    int l;
    case (sz)
      3'd0, 3'd1: l = 0;
      3'd2:       l = 1;
      3'd3:       l = 2;
      default:    l = 3;
    endcase
    return (l > lanes - 1) ? lanes - 1 : l;
  endfunction
endpackage

// File: rtl/pram_page_cache.sv
module pram_page_cache #(
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PAGE_W-1:0] cmp_page_i,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] load_page_i,
  output logic              hit_o
);
  logic [PAGE_W-1:0] cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_q <= '1;
    else if (load_i) cur_q <= load_page_i;
  end

  assign hit_o = (cmp_page_i == cur_q);
endmodule

// File: rtl/pram_lanes.sv
module pram_lanes #(
  parameter int LANE_W    = 16,
  parameter int NUM_LANES = 4,
  localparam int DATA_W   = LANE_W * NUM_LANES,
  localparam int IDX_W    = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic              byte_only_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [LANE_W-1:0] wlane_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [LANE_W-1:0] wd_q [NUM_LANES];
  logic [LANE_W-1:0] rd_q [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     wd_q[g] <= '0;
      else if (load_i) wd_q[g] <= wdata_i[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 rd_q[g] <= '0;
      else if (clr_i)                              rd_q[g] <= '0;
      else if (cap_i && (idx_i == IDX_W'(g))) begin
        if (byte_only_i) rd_q[g] <= {{(LANE_W-8){1'b0}}, lane_i[7:0]};
        else             rd_q[g] <= lane_i;
      end
    end

    assign rdata_o[g*LANE_W +: LANE_W] = rd_q[g];
  end

  assign wlane_o = wd_q[idx_i];
endmodule

// File: rtl/pram_seq.sv
module pram_seq
  import pram_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter int POLL_LIMIT = 5,
  parameter int GAP_W      = 8,
  localparam int IDX_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1,
  localparam int PC_W      = $clog2(POLL_LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             write_i,
  input  logic [2:0]       size_i,
  input  logic             page_hit_i,
  input  logic [GAP_W-1:0] poll_gap_i,
  input  logic             ack_i,
  input  logic             err_i,
  input  logic [1:0]       busy_bits_i,
  output seq_state_e       state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             write_o,
  output logic             page_load_o,
  output logic             clr_o,
  output logic             cap_o,
  output logic             done_o,
  output logic             fail_o
);
  seq_state_e       st_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic [PC_W-1:0]  poll_q;
  logic [GAP_W-1:0] gap_q;
  logic             wr_q, err_q;
  logic             in_txn, ok_ack, still_busy, fail_ev, start_ok;

  assign in_txn     = (st_q == ST_PAGE) || (st_q == ST_WDATA) || (st_q == ST_CMD) ||
                      (st_q == ST_POLL) || (st_q == ST_RDATA);
  assign ok_ack     = ack_i && !err_i;
  assign still_busy = (busy_bits_i != 2'b00);
  assign start_ok   = start_i && (st_q == ST_IDLE);
  assign fail_ev    = (in_txn && ack_i && err_i) ||
                      ((st_q == ST_POLL) && ok_ack && still_busy &&
                       (poll_q == PC_W'(POLL_LIMIT - 1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      last_q <= '0;
      poll_q <= '0;
      gap_q  <= '0;
      wr_q   <= 1'b0;
      err_q  <= 1'b0;
    end else if (fail_ev) begin
      err_q <= 1'b1;
      st_q  <= ST_FIN;
    end else begin
      case (st_q)
        ST_IDLE: if (start_ok) begin
          wr_q   <= write_i;
          last_q <= IDX_W'(size_last_lane(size_i, NUM_LANES));
          idx_q  <= '0;
          poll_q <= '0;
          err_q  <= 1'b0;
          if (!page_hit_i) st_q <= ST_PAGE;
          else             st_q <= write_i ? ST_WDATA : ST_CMD;
        end
        ST_PAGE: if (ok_ack) st_q <= wr_q ? ST_WDATA : ST_CMD;
        ST_WDATA: if (ok_ack) begin
          if (idx_q == last_q) begin
            idx_q <= '0;
            st_q  <= ST_CMD;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_CMD: if (ok_ack) st_q <= ST_POLL;
        ST_POLL: if (ok_ack) begin
          if (!still_busy) begin
            idx_q <= '0;
            st_q  <= wr_q ? ST_FIN : ST_RDATA;
          end else begin
            poll_q <= poll_q + 1'b1;
            gap_q  <= poll_gap_i;
            st_q   <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_q == '0) st_q <= ST_POLL;
          else             gap_q <= gap_q - 1'b1;
        end
        ST_RDATA: if (ok_ack) begin
          if (idx_q == last_q) st_q <= ST_FIN;
          else                 idx_q <= idx_q + 1'b1;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o     = st_q;
  assign idx_o       = idx_q;
  assign write_o     = wr_q;
  assign page_load_o = (st_q == ST_PAGE) && ok_ack;
  assign clr_o       = start_ok || fail_ev;
  assign cap_o       = (st_q == ST_RDATA) && ok_ack;
  assign done_o      = (st_q == ST_FIN);
  assign fail_o      = (st_q == ST_FIN) && err_q;
endmodule

// File: rtl/paged_reg_master.sv
module paged_reg_master
  import pram_pkg::*;
#(
  parameter int PAGE_W     = 8,
  parameter int OFS_W      = 8,
  parameter int LANE_W     = 16,
  parameter int NUM_LANES  = 4,
  parameter int POLL_LIMIT = 5,
  parameter int GAP_W      = 8,
  parameter int PHY_W      = 5,
  parameter int PHY_ADDR   = 30,
  localparam int DATA_W    = LANE_W * NUM_LANES,
  localparam int IDX_W     = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [PAGE_W-1:0] req_page_i,
  input  logic [OFS_W-1:0]  req_ofs_i,
  input  logic              req_write_i,
  input  logic [2:0]        req_size_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [GAP_W-1:0]  poll_gap_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mgmt_req_o,
  output logic              mgmt_we_o,
  output logic [PHY_W-1:0]  mgmt_phy_o,
  output logic [MREG_W-1:0] mgmt_reg_o,
  output logic [LANE_W-1:0] mgmt_wdata_o,
  input  logic              mgmt_ack_i,
  input  logic              mgmt_err_i,
  input  logic [LANE_W-1:0] mgmt_rdata_i
);
  seq_state_e        st;
  logic [IDX_W-1:0]  idx;
  logic              wr, page_load, clr, cap, hit, start;
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  ofs_q;
  logic              byte_q;
  logic [LANE_W-1:0] wlane;

  assign start = req_valid_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      ofs_q  <= '0;
      byte_q <= 1'b0;
    end else if (start) begin
      page_q <= req_page_i;
      ofs_q  <= req_ofs_i;
      byte_q <= (req_size_i == 3'd0);
    end
  end

  pram_page_cache #(.PAGE_W(PAGE_W)) u_cache (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmp_page_i (req_page_i),
    .load_i     (page_load),
    .load_page_i(page_q),
    .hit_o      (hit)
  );

  pram_seq #(
    .NUM_LANES (NUM_LANES),
    .POLL_LIMIT(POLL_LIMIT),
    .GAP_W     (GAP_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .write_i    (req_write_i),
    .size_i     (req_size_i),
    .page_hit_i (hit),
    .poll_gap_i (poll_gap_i),
    .ack_i      (mgmt_ack_i),
    .err_i      (mgmt_err_i),
    .busy_bits_i(mgmt_rdata_i[1:0]),
    .state_o    (st),
    .idx_o      (idx),
    .write_o    (wr),
    .page_load_o(page_load),
    .clr_o      (clr),
    .cap_o      (cap),
    .done_o     (done_o),
    .fail_o     (err_o)
  );

  pram_lanes #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_lanes (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .wdata_i    (req_wdata_i),
    .clr_i      (clr),
    .cap_i      (cap),
    .byte_only_i(byte_q),
    .idx_i      (idx),
    .lane_i     (mgmt_rdata_i),
    .wlane_o    (wlane),
    .rdata_o    (rdata_o)
  );

  assign busy_o     = (st != ST_IDLE);
  assign mgmt_phy_o = PHY_W'(PHY_ADDR);

  always_comb begin
    mgmt_req_o   = 1'b0;
    mgmt_we_o    = 1'b0;
    mgmt_reg_o   = MREG_CMD;
    mgmt_wdata_o = '0;
    case (st)
      ST_PAGE: begin
        mgmt_req_o   = 1'b1;
        mgmt_we_o    = 1'b1;
        mgmt_reg_o   = MREG_PAGE;
        mgmt_wdata_o = {page_q, {(LANE_W-PAGE_W-1){1'b0}}, 1'b1};
      end
      ST_WDATA: begin
        mgmt_req_o   = 1'b1;
        mgmt_we_o    = 1'b1;
        mgmt_reg_o   = MREG_DATA0 + MREG_W'(idx);
        mgmt_wdata_o = wlane;
      end
      ST_CMD: begin
        mgmt_req_o   = 1'b1;
        mgmt_we_o    = 1'b1;
        mgmt_wdata_o = {ofs_q, {(LANE_W-OFS_W-2){1'b0}}, ~wr, wr};
      end
      ST_POLL:  mgmt_req_o = 1'b1;
      ST_RDATA: begin
        mgmt_req_o = 1'b1;
        mgmt_reg_o = MREG_DATA0 + MREG_W'(idx);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pram_checker.sv
module pram_checker
  import pram_pkg::*;
#(
  parameter int LANE_W     = 16,
  parameter int POLL_LIMIT = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              mgmt_req_o,
  input logic              mgmt_we_o,
  input logic [MREG_W-1:0] mgmt_reg_o,
  input logic [LANE_W-1:0] mgmt_wdata_o,
  input logic              mgmt_ack_i
);
  logic [7:0] polls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     polls_q <= '0;
    else if (!busy_o) polls_q <= '0;
    else if (mgmt_req_o && mgmt_ack_i && !mgmt_we_o && mgmt_reg_o == MREG_CMD)
      polls_q <= polls_q + 1'b1;
  end

  assert_page_format_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mgmt_req_o && mgmt_reg_o == MREG_PAGE) |-> (mgmt_we_o && mgmt_wdata_o[0] && mgmt_wdata_o[7:1] == 7'd0));

  assert_cmd_dir_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mgmt_req_o && mgmt_we_o && mgmt_reg_o == MREG_CMD) |-> ($countones(mgmt_wdata_o[1:0]) == 1));

  assert_poll_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    polls_q <= 8'(POLL_LIMIT));

  assert_err_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  assert_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> busy_o);

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mgmt_req_o);

  assert_done_in_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mgmt_req_o && !mgmt_ack_i) |=>
      (mgmt_req_o && $stable(mgmt_we_o) && $stable(mgmt_reg_o) && $stable(mgmt_wdata_o)));
endmodule

bind paged_reg_master pram_checker #(.LANE_W(LANE_W), .POLL_LIMIT(POLL_LIMIT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .mgmt_req_o  (mgmt_req_o),
  .mgmt_we_o   (mgmt_we_o),
  .mgmt_reg_o  (mgmt_reg_o),
  .mgmt_wdata_o(mgmt_wdata_o),
  .mgmt_ack_i  (mgmt_ack_i)
);

// File: tb/sim_paged_reg_master.sv
`timescale 1ns/1ps
module sim_paged_reg_master;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [7:0]  req_page_i = '0;
  logic [7:0]  req_ofs_i = '0;
  logic        req_write_i = 1'b0;
  logic [2:0]  req_size_i = '0;
  logic [63:0] req_wdata_i = '0;
  logic [7:0]  poll_gap_i = '0;
  logic        busy_o, done_o, err_o;
  logic [63:0] rdata_o;
  logic        mgmt_req_o, mgmt_we_o;
  logic [4:0]  mgmt_phy_o, mgmt_reg_o;
  logic [15:0] mgmt_wdata_o;
  logic        mgmt_ack_i = 1'b0;
  logic        mgmt_err_i = 1'b0;
  logic [15:0] mgmt_rdata_i = '0;

  always #10 clk_i = ~clk_i;

  paged_reg_master u0 (.*);

  int n_vec = 0, n_bad = 0;
  logic [21:0] exp_q [$];
  logic [15:0] dreg [4];
  logic [7:0]  mcache = 8'hFF;
  int lat = 0, busy_polls = 0, err_at = -1, gap_cfg = 0;
  int txn_idx = 0, poll_seen = 0, idle_cnt = 0, cnt = 0;
  bit in_req = 0, first_txn = 0, last_was_poll = 0, active = 0;
  logic [4:0]  cap_reg;
  logic [15:0] cap_wd;
  logic        cap_we;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic we, input logic [4:0] r);
    if (r == 5'h10) return "R1";
    if (r == 5'h11) return we ? "R4" : "R5";
    return we ? "R3" : "R7";
  endfunction

  // management responder and transaction monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      mgmt_ack_i = 1'b0;
      mgmt_err_i = 1'b0;
      if (mgmt_req_o) begin
        if (!active) begin
          active  = 1;
          cnt     = 0;
          cap_reg = mgmt_reg_o;
          cap_we  = mgmt_we_o;
          cap_wd  = mgmt_wdata_o;
          if (in_req && !first_txn) begin
            if (cap_reg == 5'h11 && !cap_we && last_was_poll)
              check(idle_cnt == gap_cfg + 1, "R5", "poll gap", 64'(idle_cnt), 64'(gap_cfg + 1));
            else
              check(idle_cnt == 0, "R10", "back-to-back gap", 64'(idle_cnt), 64'd0);
          end
          first_txn = 0;
        end else begin
          check(mgmt_reg_o == cap_reg && mgmt_we_o == cap_we && mgmt_wdata_o == cap_wd,
                "R10", "request held stable", {mgmt_we_o, mgmt_reg_o, mgmt_wdata_o},
                {cap_we, cap_reg, cap_wd});
        end
        if (cnt >= lat) begin
          logic [21:0] got;
          got = {cap_we, cap_reg, cap_we ? cap_wd : 16'h0};
          if (exp_q.size() == 0) check(0, "R9", "unexpected transaction", 64'(got), 64'h0);
          else begin
            logic [21:0] e;
            e = exp_q.pop_front();
            check(got == e, tag_of(cap_we, cap_reg), "transaction", 64'(got), 64'(e));
          end
          check(mgmt_phy_o == 5'd30, "R4", "device address", 64'(mgmt_phy_o), 64'd30);
          mgmt_ack_i = 1'b1;
          mgmt_err_i = (txn_idx == err_at);
          mgmt_rdata_i = 16'hDEAD;
          if (!cap_we && cap_reg == 5'h11) begin
            mgmt_rdata_i = (poll_seen < busy_polls) ? {14'h0, poll_seen[0] ? 2'b10 : 2'b01}
                                                     : 16'h0;
            poll_seen++;
          end else if (!cap_we && cap_reg >= 5'h18 && cap_reg <= 5'h1B) begin
            mgmt_rdata_i = dreg[cap_reg - 5'h18];
          end else if (cap_we && cap_reg >= 5'h18 && cap_reg <= 5'h1B && !mgmt_err_i) begin
            dreg[cap_reg - 5'h18] = cap_wd;
          end
          last_was_poll = !cap_we && cap_reg == 5'h11;
          idle_cnt = 0;
          txn_idx++;
          active = 0;
        end else cnt++;
      end else if (!active) idle_cnt++;
    end
  end

  task automatic do_req(input logic [7:0] page, input logic [7:0] ofs, input bit wr,
                        input logic [2:0] size, input logic [63:0] wdata, input int bp,
                        input int ea, input int gap, input int latency, input bit poke,
                        input string name);
    int nl, np, k;
    bit exp_err;
    logic [63:0] exp_rd;
    logic [21:0] q [$];
    nl = (size <= 3'd1) ? 1 : (size == 3'd2) ? 2 : (size == 3'd3) ? 3 : 4;
    if (page != mcache) q.push_back({1'b1, 5'h10, page, 8'h01});
    if (wr) for (int i = 0; i < nl; i++) q.push_back({1'b1, 5'(5'h18 + i), wdata[16*i +: 16]});
    q.push_back({1'b1, 5'h11, ofs, 6'b0, ~wr, wr});
    np = (bp >= 5) ? 5 : bp + 1;
    for (int i = 0; i < np; i++) q.push_back({1'b0, 5'h11, 16'h0});
    if (bp < 5 && !wr) for (int i = 0; i < nl; i++) q.push_back({1'b0, 5'(5'h18 + i), 16'h0});
    exp_err = (bp >= 5);
    if (ea >= 0 && ea < q.size()) begin
      while (q.size() > ea + 1) void'(q.pop_back());
      exp_err = 1;
    end
    if (page != mcache && ea != 0) mcache = page;
    exp_rd = '0;
    if (!exp_err && !wr) begin
      for (int i = 0; i < nl; i++) exp_rd[16*i +: 16] = dreg[i];
      if (size == 3'd0) exp_rd = exp_rd & 64'hFF;
    end
    busy_polls = bp; err_at = ea; gap_cfg = gap; lat = latency;
    txn_idx = 0; poll_seen = 0; exp_q = q; first_txn = 1; last_was_poll = 0;

    @(negedge clk_i);
    req_valid_i = 1'b1; req_page_i = page; req_ofs_i = ofs; req_write_i = wr;
    req_size_i = size; req_wdata_i = wdata; poll_gap_i = 8'(gap);
    in_req = 1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(busy_o == 1'b1, "R9", {name, " busy after accept"}, 64'(busy_o), 64'd1);
    k = 0;
    while (!done_o && k < 400) begin
      if (poke && k == 2) begin
        req_valid_i = 1'b1; req_page_i = 8'h55; req_write_i = 1'b1;
      end else req_valid_i = 1'b0;
      @(negedge clk_i);
      k++;
      if (!done_o) check(busy_o == 1'b1, "R9", {name, " busy held"}, 64'(busy_o), 64'd1);
    end
    req_valid_i = 1'b0;
    check(done_o == 1'b1, "R10", {name, " done seen"}, 64'(done_o), 64'd1);
    check(err_o == exp_err, exp_err ? ((bp >= 5) ? "R6" : "R8") : "R8", {name, " error flag"},
          64'(err_o), 64'(exp_err));
    check(rdata_o == exp_rd, wr ? "R6" : "R7", {name, " read data"}, rdata_o, exp_rd);
    check(exp_q.size() == 0, "R3", {name, " all transactions issued"}, 64'(exp_q.size()), 64'd0);
    check(busy_o == 1'b1, "R9", {name, " busy in done cycle"}, 64'(busy_o), 64'd1);
    @(negedge clk_i);
    check(done_o == 1'b0 && busy_o == 1'b0, "R10", {name, " single done pulse"},
          {62'd0, done_o, busy_o}, 64'd0);
    in_req = 0;
  endtask

  initial begin
    dreg[0] = 16'h1111; dreg[1] = 16'h2222; dreg[2] = 16'h3333; dreg[3] = 16'h4444;
    repeat (3) @(negedge clk_i);
    check(busy_o == 0 && done_o == 0 && err_o == 0 && mgmt_req_o == 0, "R9", "reset state",
          {busy_o, done_o, err_o, mgmt_req_o}, 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    // R1: page 0xFF matches the reset cache
    do_req(8'hFF, 8'h04, 0, 3'd1, 64'h0, 0, -1, 0, 0, 0, "rd16_pageFF");
    do_req(8'h02, 8'h10, 1, 3'd1, 64'h0000_0000_0000_ABCD, 0, -1, 0, 1, 0, "wr16");
    do_req(8'h02, 8'h12, 0, 3'd1, 64'h0, 2, -1, 3, 0, 0, "rd16_samepage_R5");
    do_req(8'h03, 8'h20, 1, 3'd4, 64'h0123_4567_89AB_CDEF, 1, -1, 1, 2, 1, "wr64_poke_R9");
    do_req(8'h03, 8'h20, 0, 3'd4, 64'h0, 0, -1, 0, 1, 0, "rd64_R7");
    do_req(8'h03, 8'h21, 0, 3'd0, 64'h0, 0, -1, 0, 0, 0, "rd8_R7");
    do_req(8'h03, 8'h30, 1, 3'd2, 64'hFFFF_FFFF_CAFE_F00D, 4, -1, 2, 0, 0, "wr32_fifthpoll");
    do_req(8'h03, 8'h31, 0, 3'd3, 64'h0, 0, -1, 0, 2, 0, "rd48_R7");
    do_req(8'h03, 8'h32, 0, 3'd1, 64'h0, 5, -1, 1, 0, 0, "timeout_R6");
    do_req(8'h03, 8'h33, 0, 3'd4, 64'h0, 9, -1, 0, 1, 0, "timeout64_R6");
    do_req(8'h07, 8'h40, 1, 3'd0, 64'h5A, 0, 0, 0, 1, 0, "pagefail_R2");
    do_req(8'h07, 8'h41, 0, 3'd1, 64'h0, 0, -1, 0, 0, 0, "page_rewrite_R2");
    do_req(8'h07, 8'h42, 1, 3'd1, 64'h0000_0000_0000_7777, 0, 2, 0, 0, 0, "pollerr_R8");
    do_req(8'h09, 8'h43, 1, 3'd1, 64'h0000_0000_0000_8888, 0, 1, 0, 1, 0, "dataerr_R8");
    do_req(8'h09, 8'h44, 0, 3'd2, 64'h0, 0, 2, 0, 0, 0, "rdataerr_R8");
    do_req(8'h09, 8'h45, 0, 3'd2, 64'h0, 0, -1, 0, 0, 0, "cached_after_dataerr_R1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    n_bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule